// File: doc/BRIEF.md
# Interrupt Source State Controller

This block holds the per-source state for a small array of interrupt sources and turns their activity into offers for a downstream presentation stage. Each source has four configured values: a target server, a priority, a saved priority, and a fixed type. The type is either message, where an input pulse is one event, or level, where the input is a held request line. Priority `8'hFF` masks a source. Offers leave one at a time on a valid/ready port as the triple (source number, server, priority). The source number is a parameterised base plus the local index.

Three notifications come back from the presentation stage. A reject means an offer was not taken. An end-of-interrupt means a delivered interrupt has been serviced. A resend request asks every source to be re-examined. Reject and end-of-interrupt carry a full source number; the controller subtracts the base from it and ignores any number outside its range. Message and level sources follow different rules:

- A message source remembers a masked event so it can deliver it once unmasked, and it remembers a rejection so it can retry it.
- A level source tracks whether its line is asserted and whether an offer is already out. This prevents re-offering until the offer is rejected or serviced.

The offer port uses a registered slot. When the slot is empty, or is being accepted in the current cycle, the lowest-indexed eligible source is loaded into it. The slot contents stay frozen while `offer_valid` is high and `offer_ready` is low, so back-pressure simply holds the offer; nothing is dropped. A source becomes eligible one clock after the event that causes it, and its offer appears one clock after that.

Top module: `intsrc_state_ctrl`

## Requirements
- R1: After reset, `offer_valid` and `resend_done` are low. Every source is masked (priority `8'hFF`) with all status cleared, and each source keeps its type.
- R2: A message source that fires while masked produces no offer and latches a masked-pending state. A later configuration write to it with a priority other than `8'hFF` clears that state and produces one offer.
- R3: A message source that fires while unmasked produces one offer. The offer carries number = BASE + index and the configured server and priority. No offer ever carries priority `8'hFF`.
- R4: A level source is offered when it is unmasked, its input is high, and it has no offer outstanding. Loading the offer marks it sent, and it is not offered again while sent.
- R5: An end-of-interrupt addressed to a level source clears its sent state, so the source is offered again if its input is still high. An end-of-interrupt addressed to a message source changes nothing.
- R6: A reject addressed to a level source clears its sent state and so re-offers it if its input is still high. A reject addressed to a message source marks it rejected without producing an offer.
- R7: `resend_start` is ignored while a scan is running. Otherwise it starts a scan that visits one index per clock from 0 to N_SRC-1. `resend_done` pulses high for one cycle, N_SRC+1 clocks after the start edge. Each rejected message source visited has its rejected mark cleared and is re-offered only if it is unmasked at that moment.
- R8: When several sources are eligible, offers leave in ascending index order. While `offer_valid` is high and `offer_ready` is low, the offer fields stay unchanged.
- R9: A reject or end-of-interrupt whose number minus BASE is not below N_SRC (with modular subtraction, so numbers below BASE are included) has no effect.
- R10: Only a configuration write changes a source's server, priority or saved priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | N_SRC | Per-source input: an event pulse for message sources, a request level for level sources |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Local index being configured |
| cfg_server | input | SRV_W | New target server |
| cfg_prio | input | PRIO_W | New priority (`8'hFF` = masked) |
| cfg_saved | input | PRIO_W | New saved priority |
| rej_valid | input | 1 | Reject notification strobe |
| rej_num | input | NUM_W | Source number being rejected |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_num | input | NUM_W | Source number being completed |
| resend_start | input | 1 | Starts a resend scan |
| resend_done | output | 1 | One-cycle pulse at the end of a scan |
| offer_valid | output | 1 | Offer slot holds an offer |
| offer_ready | input | 1 | Presentation side takes the offer |
| offer_num | output | NUM_W | Offered source number (BASE + index) |
| offer_server | output | SRV_W | Offered target server |
| offer_prio | output | PRIO_W | Offered priority |

## Verification
On every cycle, the assertions check the following:
- the offer port holds its fields under back-pressure and never presents a masked priority;
- a grant only reaches an eligible source, at most one source is granted, and it is the lowest-indexed one;
- a level source just granted is not eligible in the next cycle;
- masked message events latch the pending state;
- configuration registers change only on a write;
- the done pulse comes only at the end of a scan.

The bench scenarios are needed for the end-to-end behaviour:
- the offer numbers and fields produced across the whole sweep of sources, priorities and servers;
- the delayed delivery after an unmask;
- re-offering after end-of-interrupt and reject, and the masked-at-rescan drop;
- rejection of out-of-range numbers and the exact scan length.

// File: rtl/intsrc_pkg.sv
package intsrc_pkg;

  typedef struct packed {
    logic queued;    // message: offer waiting for the slot
    logic mpend;     // message: fired while masked
    logic rejected;  // message: offer was turned away
    logic asserted;  // level: registered request line
    logic sent;      // level: offer outstanding
  } src_stat_t;

  localparam src_stat_t STAT_CLEAR = '0;

endpackage

// File: rtl/intsrc_entry.sv
module intsrc_entry
  import intsrc_pkg::*;
#(
  parameter int PRIO_W   = 8,
  parameter int SRV_W    = 4,
  parameter bit IS_LEVEL = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_in,
  input  logic              cfg_hit,
  input  logic [PRIO_W-1:0] cfg_prio,
  input  logic [SRV_W-1:0]  cfg_server,
  input  logic [PRIO_W-1:0] cfg_saved,
  input  logic              rej_hit,
  input  logic              eoi_hit,
  input  logic              scan_hit,
  input  logic              grant,
  output logic              eligible,
  output logic [PRIO_W-1:0] prio_o,
  output logic [SRV_W-1:0]  server_o
);

  logic [PRIO_W-1:0] prio_q, saved_q;
  logic [SRV_W-1:0]  server_q;
  src_stat_t         st_q, st_d;
  logic              masked;

  assign masked = &prio_q;

  always_comb begin
    st_d          = st_q;
    st_d.asserted = src_in;
    if (IS_LEVEL) begin
      if (rej_hit || eoi_hit) st_d.sent = 1'b0;
      if (grant)              st_d.sent = 1'b1;
    end else begin
      if (grant) st_d.queued = 1'b0;
      if (scan_hit && st_q.rejected) begin
        st_d.rejected = 1'b0;
        if (!masked) st_d.queued = 1'b1;
      end
      if (rej_hit) st_d.rejected = 1'b1;
      if (src_in) begin
        if (masked) st_d.mpend  = 1'b1;
        else        st_d.queued = 1'b1;
      end
      if (cfg_hit && !(&cfg_prio) && st_d.mpend) begin
        st_d.mpend  = 1'b0;
        st_d.queued = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= STAT_CLEAR;
      prio_q   <= '1;
      saved_q  <= '1;
      server_q <= '0;
    end else begin
      st_q <= st_d;
      if (cfg_hit) begin
        prio_q   <= cfg_prio;
        saved_q  <= cfg_saved;
        server_q <= cfg_server;
      end
    end
  end

  assign eligible = IS_LEVEL ? (st_q.asserted && !masked && !st_q.sent)
                             : (st_q.queued && !masked);
  assign prio_o   = prio_q;
  assign server_o = server_q;

  // R8: the picker only grants a source that is eligible
  assert_grant_eligible_R8: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> eligible);

  // R4: a level source just loaded into the slot is not eligible next cycle
  assert_level_no_reoffer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_LEVEL && grant) |=> !eligible);

  // R2: a masked message event latches the pending state
  assert_masked_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!IS_LEVEL && src_in && masked && !cfg_hit) |=> st_q.mpend);

  // R10: configured values move only on a write
  assert_cfg_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_hit |=> ($stable(saved_q) && $stable(prio_q) && $stable(server_q)));

endmodule

// File: rtl/intsrc_pick.sv
module intsrc_pick #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

  // R8: nothing below the chosen index is requesting
  assert_lowest_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (req[idx] && ((req & ((N'(1) << idx) - N'(1))) == '0)));

endmodule

// File: rtl/intsrc_scan.sv
module intsrc_scan #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic [N-1:0]     hit,
  output logic             done
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  logic             busy;
  logic [IDX_W-1:0] ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ptr  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        if (ptr == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
        ptr <= ptr + 1'b1;
      end else if (start) begin
        busy <= 1'b1;
        ptr  <= '0;
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_hit
    assign hit[g] = busy && (ptr == IDX_W'(g));
  end

  // R7: the done pulse only follows the visit of the last index
  assert_done_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy) && ($past(ptr) == LAST)));

  // R7: a scan visits at most one source per cycle
  assert_scan_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));

endmodule

// File: rtl/intsrc_state_ctrl.sv
module intsrc_state_ctrl
  import intsrc_pkg::*;
#(
  parameter int                N_SRC      = 8,
  parameter int                NUM_W      = 16,
  parameter int                SRV_W      = 4,
  parameter int                PRIO_W     = 8,
  parameter logic [NUM_W-1:0]  BASE       = 16'h0040,
  parameter logic [N_SRC-1:0]  LEVEL_MASK = 8'hF0,
  localparam int               IDX_W      = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_in,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [SRV_W-1:0]  cfg_server,
  input  logic [PRIO_W-1:0] cfg_prio,
  input  logic [PRIO_W-1:0] cfg_saved,
  input  logic              rej_valid,
  input  logic [NUM_W-1:0]  rej_num,
  input  logic              eoi_valid,
  input  logic [NUM_W-1:0]  eoi_num,
  input  logic              resend_start,
  output logic              resend_done,
  output logic              offer_valid,
  input  logic              offer_ready,
  output logic [NUM_W-1:0]  offer_num,
  output logic [SRV_W-1:0]  offer_server,
  output logic [PRIO_W-1:0] offer_prio
);

  logic [NUM_W-1:0]  rej_loc, eoi_loc;
  logic              rej_in, eoi_in;
  logic [N_SRC-1:0]  eligible, grant, scan_hit;
  logic [PRIO_W-1:0] prio_a   [N_SRC];
  logic [SRV_W-1:0]  server_a [N_SRC];
  logic              pick_any, load;
  logic [IDX_W-1:0]  pick_idx;

  assign rej_loc = rej_num - BASE;
  assign eoi_loc = eoi_num - BASE;
  assign rej_in  = rej_valid && (rej_loc < NUM_W'(N_SRC));
  assign eoi_in  = eoi_valid && (eoi_loc < NUM_W'(N_SRC));

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    intsrc_entry #(
      .PRIO_W   (PRIO_W),
      .SRV_W    (SRV_W),
      .IS_LEVEL (LEVEL_MASK[g])
    ) u_entry (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_in     (src_in[g]),
      .cfg_hit    (cfg_we && (cfg_idx == IDX_W'(g))),
      .cfg_prio   (cfg_prio),
      .cfg_server (cfg_server),
      .cfg_saved  (cfg_saved),
      .rej_hit    (rej_in && (rej_loc == NUM_W'(g))),
      .eoi_hit    (eoi_in && (eoi_loc == NUM_W'(g))),
      .scan_hit   (scan_hit[g]),
      .grant      (grant[g]),
      .eligible   (eligible[g]),
      .prio_o     (prio_a[g]),
      .server_o   (server_a[g])
    );
    assign grant[g] = load && (pick_idx == IDX_W'(g));
  end

  intsrc_pick #(.N(N_SRC), .IDX_W(IDX_W)) u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (eligible),
    .any   (pick_any),
    .idx   (pick_idx)
  );

  intsrc_scan #(.N(N_SRC), .IDX_W(IDX_W)) u_scan (
    .clk   (clk),
    .rst_n (rst_n),
    .start (resend_start),
    .hit   (scan_hit),
    .done  (resend_done)
  );

  assign load = pick_any && (!offer_valid || offer_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      offer_valid  <= 1'b0;
      offer_num    <= '0;
      offer_server <= '0;
      offer_prio   <= '1;
    end else if (load) begin
      offer_valid  <= 1'b1;
      offer_num    <= BASE + NUM_W'(pick_idx);
      offer_server <= server_a[pick_idx];
      offer_prio   <= prio_a[pick_idx];
    end else if (offer_ready) begin
      offer_valid  <= 1'b0;
    end
  end

  // R8: back-pressure freezes the offer
  assert_offer_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (offer_valid && !offer_ready) |=>
      (offer_valid && $stable(offer_num) && $stable(offer_server) && $stable(offer_prio)));

  // R3: a masked priority is never offered
  assert_offer_unmasked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    offer_valid |-> (offer_prio != '1));

  // R8: at most one source is loaded per cycle
  assert_grant_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

endmodule

// File: tb/intsrc_state_ctrl_tb.sv
`timescale 1ns/1ps
module intsrc_state_ctrl_tb;

  localparam int          N    = 8;
  localparam logic [15:0] BASE = 16'h0040;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [N-1:0] src_in;
  logic        cfg_we;
  logic [2:0]  cfg_idx;
  logic [3:0]  cfg_server;
  logic [7:0]  cfg_prio, cfg_saved;
  logic        rej_valid, eoi_valid, resend_start, offer_ready;
  logic [15:0] rej_num, eoi_num;
  logic        resend_done, offer_valid;
  logic [15:0] offer_num;
  logic [3:0]  offer_server;
  logic [7:0]  offer_prio;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  intsrc_state_ctrl #(
    .N_SRC(N), .NUM_W(16), .SRV_W(4), .PRIO_W(8), .BASE(BASE), .LEVEL_MASK(8'hF0)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_server(cfg_server),
    .cfg_prio(cfg_prio), .cfg_saved(cfg_saved),
    .rej_valid(rej_valid), .rej_num(rej_num),
    .eoi_valid(eoi_valid), .eoi_num(eoi_num),
    .resend_start(resend_start), .resend_done(resend_done),
    .offer_valid(offer_valid), .offer_ready(offer_ready),
    .offer_num(offer_num), .offer_server(offer_server), .offer_prio(offer_prio)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input int idx, input int srv, input int prio);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_server = 4'(srv);
    cfg_prio = 8'(prio); cfg_saved = 8'(prio ^ 8'h11);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic fire(input logic [N-1:0] m);
    @(negedge clk); src_in = src_in | m;
    @(negedge clk); src_in = src_in & ~m;
  endtask

  task automatic reject(input logic [15:0] num);
    @(negedge clk); rej_valid = 1'b1; rej_num = num;
    @(negedge clk); rej_valid = 1'b0;
  endtask

  task automatic eoi(input logic [15:0] num);
    @(negedge clk); eoi_valid = 1'b1; eoi_num = num;
    @(negedge clk); eoi_valid = 1'b0;
  endtask

  // wait for an offer, compare it, then accept it
  task automatic take(input string req, input int idx, input int srv, input int prio);
    int w = 0;
    while (!offer_valid && w < N + 6) begin
      @(negedge clk); w++;
    end
    chk({req, " valid"}, 32'(offer_valid), 32'd1);
    chk({req, " num"}, 32'(offer_num), 32'(BASE + 16'(idx)));
    chk({req, " server"}, 32'(offer_server), 32'(srv));
    chk({req, " prio"}, 32'(offer_prio), 32'(prio));
    offer_ready = 1'b1;
    @(negedge clk);
    offer_ready = 1'b0;
  endtask

  task automatic none(input string req, input int cycles);
    logic seen = 1'b0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (offer_valid) seen = 1'b1;
    end
    chk({req, " no offer"}, 32'(seen), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; src_in = '0; cfg_we = 1'b0; cfg_idx = '0; cfg_server = '0;
    cfg_prio = '0; cfg_saved = '0; rej_valid = 1'b0; eoi_valid = 1'b0;
    rej_num = '0; eoi_num = '0; resend_start = 1'b0; offer_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 offer_valid", 32'(offer_valid), 32'd0);
    chk("R1 resend_done", 32'(resend_done), 32'd0);
    fire(8'h01);
    none("R1 R2 masked after reset", 4);
    cfg(0, 3, 9);
    take("R2 unmask delivers", 0, 3, 9);
    none("R2 single delivery", 3);

    // R3 sweep message sources over priorities and servers
    for (int i = 0; i < 4; i++) begin
      for (int p = 0; p < 3; p++) begin
        int pr = (p == 0) ? 0 : (p == 1) ? (i * 37 + 5) : 8'hFE;
        int sv = (i * 3 + p * 5) % 16;
        cfg(i, sv, pr);
        fire(8'(1 << i));
        take("R3 message offer", i, sv, pr);
      end
    end

    // R4 R5 R6 level sources
    for (int i = 4; i < 8; i++) begin
      int sv = 15 - i;
      int pr = i * 11;
      cfg(i, sv, pr);
      @(negedge clk); src_in[i] = 1'b1;
      take("R4 level offer", i, sv, pr);
      none("R4 sent blocks repeat", 4);
      eoi(BASE + 16'(i));
      take("R5 eoi re-offers", i, sv, pr);
      reject(BASE + 16'(i));
      take("R6 reject re-offers", i, sv, pr);
      reject(16'(i));              // below BASE wraps out of range
      reject(BASE + 16'(N));       // just past the top
      eoi(BASE + 16'(N + i));
      none("R9 out of range ignored", 3);
      @(negedge clk); src_in[i] = 1'b0;
      eoi(BASE + 16'(i));
      none("R4 deasserted stays quiet", 3);
    end

    // R5 end-of-interrupt has no effect on a message source
    cfg(1, 6, 20);
    fire(8'h02);
    take("R5 message offer", 1, 6, 20);
    eoi(BASE + 16'd1);
    none("R5 message eoi", 4);

    // R6 R7 reject then resend re-offers; scan length
    reject(BASE + 16'd1);
    none("R6 message reject quiet", 3);
    @(negedge clk); resend_start = 1'b1;
    @(negedge clk); resend_start = 1'b0;
    begin
      logic early = 1'b0;
      for (int c = 1; c <= N; c++) begin
        if (resend_done) early = 1'b1;
        if (c < N) @(negedge clk);
      end
      chk("R7 done not early", 32'(early), 32'd0);
      @(negedge clk);
      chk("R7 done after N+1", 32'(resend_done), 32'd1);
      @(negedge clk);
      chk("R7 done one cycle", 32'(resend_done), 32'd0);
    end
    take("R7 resend re-offer", 1, 6, 20);

    // R7 rejected but masked at scan time is dropped
    reject(BASE + 16'd1);
    cfg(1, 6, 8'hFF);
    @(negedge clk); resend_start = 1'b1;
    @(negedge clk); resend_start = 1'b0;
    none("R7 masked at scan", N + 3);
    cfg(1, 6, 20);
    none("R7 rejected mark cleared", 4);

    // R8 ordering and hold under back-pressure
    cfg(0, 1, 40); cfg(2, 2, 41); cfg(3, 4, 42);
    fire(8'h0D);
    @(negedge clk);
    chk("R8 first lowest", 32'(offer_num), 32'(BASE));
    repeat (3) @(negedge clk);
    chk("R8 held num", 32'(offer_num), 32'(BASE));
    chk("R8 held prio", 32'(offer_prio), 32'd40);
    take("R8 order 0", 0, 1, 40);
    take("R8 order 2", 2, 2, 41);
    take("R8 order 3", 3, 4, 42);

    // R1 mid-run reset keeps types and masks all
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R1 reset clears offer", 32'(offer_valid), 32'd0);
    @(negedge clk); src_in[5] = 1'b1;
    none("R1 level masked after reset", 3);
    cfg(5, 7, 3);
    take("R1 type kept level", 5, 7, 3);
    none("R1 level sent", 3);
    @(negedge clk); src_in[5] = 1'b0;

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule